// File: doc/BRIEF.md
# Low-Power DDR Power-Up Initialization Sequencer

This block sits on the controller side of a low-power DDR SDRAM interface. It takes the memory from reset to a usable state. While reset is asserted and afterwards, it holds clock-enable high and issues only NOP commands for a long stabilization interval. It then steps through a fixed bring-up order:

- precharge of every bank;
- a configurable number of auto-refresh commands;
- a load of the normal mode register;
- when the configuration needs it, a load of the extended mode register.

After the last load's settling delay it raises a ready flag. Every wait is a cycle count taken from a parameter, so the same logic serves any clock rate.

Software-visible settings arrive as static configuration pins: burst length, burst ordering, the fraction of the array kept alive in self-refresh, and output drive strength. Once the block is ready, a request pin rewrites the extended mode register without repeating power-up. The request is taken only while the surrounding controller reports that all banks are idle. Data transfer, read/write scheduling and periodic refresh belong to other blocks.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is asserted, the block drives clock-enable high, drives a NOP (chip-select low; row strobe, column strobe and write enable high; bank and address lines low) and holds ready low.
- R2: Clock-enable is high in every cycle. After reset release, only NOP is driven for the first T_STABLE cycles. Every cycle that carries no sequence command is a NOP with bank and address lines low.
- R3: The cycle numbered T_STABLE after reset release (the first cycle after release is cycle 1) carries a precharge-all command. Its encoding is chip-select low, row strobe low, column strobe high and write enable low, with address bit 10 high, all other address bits low and bank lines low.
- R4: N_AREF auto-refresh commands follow. Their encoding is chip-select low, row strobe low, column strobe low and write enable high, with bank and address lines low. The first comes T_RP cycles after the precharge, and each later one comes T_ARFC cycles after the previous one.
- R5: T_ARFC cycles after the last auto-refresh, a mode-register load (all four strobes low) is issued with bank code 00. Its address word is built as follows:
  - A2:A0 carry the burst length code, from cfg_burst_sel 00 → 001 (2 beats), 01 → 010 (4 beats), and 10 or 11 → 011 (8 beats).
  - A3 carries cfg_interleave.
  - A6:A4 carry 011 (CAS latency 3).
  - All other address bits are low.
- R6: T_MRD cycles after the mode-register load, an extended-register load with bank code 10 is issued, but only when the array coverage is not full or the drive strength is not half. Its address word is built as follows:
  - A2:A0 carry the coverage, from cfg_pasr_sel 00 → 000 (full), 01 → 001 (half), 10 → 010 (quarter), and 11 → 000 (full).
  - A6:A5 carry cfg_drive_sel unchanged (00 full, 01 half, 10 quarter, 11 eighth).
  - All other address bits are low.
- R7: Ready rises T_MRD cycles after the last mode-register or extended-register load of the bring-up and stays high without further requests.
- R8: A request seen while ready and banks idle causes an extended-register load in the next cycle, built from the current settings as in R6 even when they are the defaults. Ready is low from that cycle for T_MRD cycles and then returns high. No precharge or refresh is repeated.
- R9: A request made before ready, or while banks are not idle, is ignored: commands stay NOP and ready keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_burst_sel | input | 2 | Burst length selection |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_pasr_sel | input | 2 | Self-refresh array coverage selection |
| cfg_drive_sel | input | 2 | Output drive strength selection |
| emrs_req | input | 1 | Request to rewrite the extended register |
| banks_idle | input | 1 | All banks are precharged |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address (BANK_W) |
| mem_addr | output | 13 | Address lines (ROW_W) |
| init_ready | output | 1 | Memory initialized and usable |

## Verification
Each state of the sequencer corresponds to a single command or a NOP on the command pins. A wrong state or a miscounted wait therefore appears as a command in the wrong cycle, usually within one interval length of the fault. It can also appear as an extra or missing refresh, or as ready rising early or late. A bad settings decode is visible in the address word of the register-load cycle itself, and a wrongly taken or dropped request changes ready in the very next cycle. The bench predicts every port value for every cycle from a timeline built from the requirements, so any of these faults is reported in the cycle where it first appears.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_PRE,
      CMD_AREF,
      CMD_MODE
   } mem_cmd_e;

   typedef enum logic [3:0] {
      ST_STABLE,
      ST_PRE,
      ST_PRE_WAIT,
      ST_AREF,
      ST_AREF_WAIT,
      ST_MRS,
      ST_MRS_WAIT,
      ST_EMRS,
      ST_EMRS_WAIT,
      ST_READY
   } init_state_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   function automatic cmd_pins_t encode_cmd(input mem_cmd_e c);
      cmd_pins_t p;
      unique case (c)
         CMD_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         CMD_AREF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         CMD_MODE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
         default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/lpddr_init_timer.sv
module lpddr_init_timer #(
   parameter int unsigned W         = 16,
   parameter int unsigned RESET_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   if (W < 1 || W > 31) begin : g_bad_width
      $error("lpddr_init_timer: W out of range");
   end
   if (RESET_VAL >= (32'd1 << W)) begin : g_bad_reset
      $error("lpddr_init_timer: RESET_VAL does not fit in W bits");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(RESET_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign expired = (cnt_q == '0);

   // R2: once run out, the timer stays expired until it is reloaded
   a_r2_timer_settles: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

endmodule

// File: rtl/lpddr_mode_word.sv
module lpddr_mode_word #(
   parameter int unsigned ROW_W   = 13,
   parameter int unsigned CAS_LAT = 3
) (
   input  logic [1:0]       burst_sel,
   input  logic             interleave,
   input  logic [1:0]       pasr_sel,
   input  logic [1:0]       drive_sel,
   output logic [ROW_W-1:0] mrs_word,
   output logic [ROW_W-1:0] emrs_word,
   output logic             emrs_needed
);

   if (ROW_W < 11) begin : g_bad_row
      $error("lpddr_mode_word: ROW_W must be at least 11");
   end
   if (CAS_LAT != 3) begin : g_bad_cl
      $error("lpddr_mode_word: only CAS latency 3 is supported");
   end

   localparam logic [2:0] CL_CODE   = 3'(CAS_LAT);
   localparam logic [1:0] DRV_HALF  = 2'b01;

   logic [2:0] bl_code;
   logic [2:0] pasr_code;

   always_comb begin
      unique case (burst_sel)
         2'b00:   bl_code = 3'b001;
         2'b01:   bl_code = 3'b010;
         default: bl_code = 3'b011;
      endcase
      unique case (pasr_sel)
         2'b01:   pasr_code = 3'b001;
         2'b10:   pasr_code = 3'b010;
         default: pasr_code = 3'b000;
      endcase
   end

   always_comb begin
      mrs_word      = '0;
      mrs_word[2:0] = bl_code;
      mrs_word[3]   = interleave;
      mrs_word[6:4] = CL_CODE;
   end

   always_comb begin
      emrs_word      = '0;
      emrs_word[2:0] = pasr_code;
      emrs_word[6:5] = drive_sel;
   end

   assign emrs_needed = (pasr_code != 3'b000) || (drive_sel != DRV_HALF);

endmodule

// File: rtl/lpddr_cmd_drive.sv
module lpddr_cmd_drive
   import lpddr_init_pkg::*;
#(
   parameter int unsigned ROW_W  = 13,
   parameter int unsigned BANK_W = 2
) (
   input  mem_cmd_e          cmd,
   input  logic              ext_sel,
   input  logic [ROW_W-1:0]  mode_word,
   output cmd_pins_t         pins,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr
);

   localparam int unsigned AP_BIT  = 10;
   localparam int unsigned EXT_BIT = 1;

   always_comb begin
      pins = encode_cmd(cmd);
      ba   = '0;
      addr = '0;
      unique case (cmd)
         CMD_PRE:  addr[AP_BIT] = 1'b1;
         CMD_MODE: begin
            addr        = mode_word;
            ba[EXT_BIT] = ext_sel;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
   import lpddr_init_pkg::*;
#(
   parameter int unsigned ROW_W    = 13,
   parameter int unsigned BANK_W   = 2,
   parameter int unsigned CAS_LAT  = 3,
   parameter int unsigned T_STABLE = 40000,
   parameter int unsigned T_RP     = 4,
   parameter int unsigned T_ARFC   = 16,
   parameter int unsigned T_MRD    = 2,
   parameter int unsigned N_AREF   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_burst_sel,
   input  logic              cfg_interleave,
   input  logic [1:0]        cfg_pasr_sel,
   input  logic [1:0]        cfg_drive_sel,
   input  logic              emrs_req,
   input  logic              banks_idle,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [BANK_W-1:0] mem_ba,
   output logic [ROW_W-1:0]  mem_addr,
   output logic              init_ready
);

   localparam int unsigned T_GAP_MAX = (T_RP > T_ARFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                                      : ((T_ARFC > T_MRD) ? T_ARFC : T_MRD);
   localparam int unsigned T_MAX     = (T_STABLE > T_GAP_MAX) ? T_STABLE : T_GAP_MAX;
   localparam int unsigned TW        = $clog2(T_MAX + 1);
   localparam int unsigned CW        = $clog2(N_AREF + 1);

   if (N_AREF < 2) begin : g_bad_aref
      $error("lpddr_init_seq: at least two refresh commands are required");
   end
   if (T_RP < 2 || T_ARFC < 2 || T_MRD < 2 || T_STABLE < 1) begin : g_bad_timing
      $error("lpddr_init_seq: command spacing must be two cycles or more");
   end
   if (BANK_W < 2) begin : g_bad_bank
      $error("lpddr_init_seq: BANK_W must be at least 2");
   end

   init_state_e       state_q, state_d;
   logic [CW-1:0]     aref_q;
   logic              tmr_load;
   logic [TW-1:0]     tmr_val;
   logic              tmr_expired;
   mem_cmd_e          cmd;
   logic              ext_sel;
   logic [ROW_W-1:0]  mrs_word, emrs_word, mode_word;
   logic              emrs_needed;
   cmd_pins_t         pins;

   // wait loads: a command state always hands over to its wait state
   always_comb begin
      tmr_load = 1'b1;
      unique case (state_q)
         ST_PRE:           tmr_val = TW'(T_RP - 2);
         ST_AREF:          tmr_val = TW'(T_ARFC - 2);
         ST_MRS, ST_EMRS:  tmr_val = TW'(T_MRD - 2);
         default: begin
            tmr_load = 1'b0;
            tmr_val  = '0;
         end
      endcase
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_STABLE:    if (tmr_expired) state_d = ST_PRE;
         ST_PRE:       state_d = ST_PRE_WAIT;
         ST_PRE_WAIT:  if (tmr_expired) state_d = ST_AREF;
         ST_AREF:      state_d = ST_AREF_WAIT;
         ST_AREF_WAIT: if (tmr_expired)
                          state_d = (aref_q == CW'(N_AREF)) ? ST_MRS : ST_AREF;
         ST_MRS:       state_d = ST_MRS_WAIT;
         ST_MRS_WAIT:  if (tmr_expired)
                          state_d = emrs_needed ? ST_EMRS : ST_READY;
         ST_EMRS:      state_d = ST_EMRS_WAIT;
         ST_EMRS_WAIT: if (tmr_expired) state_d = ST_READY;
         ST_READY:     if (emrs_req && banks_idle) state_d = ST_EMRS;
         default:      state_d = ST_STABLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_STABLE;
         aref_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_AREF) aref_q <= aref_q + CW'(1);
      end
   end

   lpddr_init_timer #(
      .W         (TW),
      .RESET_VAL (T_STABLE - 1)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   lpddr_mode_word #(
      .ROW_W   (ROW_W),
      .CAS_LAT (CAS_LAT)
   ) i_mode_word (
      .burst_sel   (cfg_burst_sel),
      .interleave  (cfg_interleave),
      .pasr_sel    (cfg_pasr_sel),
      .drive_sel   (cfg_drive_sel),
      .mrs_word    (mrs_word),
      .emrs_word   (emrs_word),
      .emrs_needed (emrs_needed)
   );

   always_comb begin
      unique case (state_q)
         ST_PRE:           cmd = CMD_PRE;
         ST_AREF:          cmd = CMD_AREF;
         ST_MRS, ST_EMRS:  cmd = CMD_MODE;
         default:          cmd = CMD_NOP;
      endcase
   end

   assign ext_sel   = (state_q == ST_EMRS);
   assign mode_word = ext_sel ? emrs_word : mrs_word;

   lpddr_cmd_drive #(
      .ROW_W  (ROW_W),
      .BANK_W (BANK_W)
   ) i_cmd_drive (
      .cmd       (cmd),
      .ext_sel   (ext_sel),
      .mode_word (mode_word),
      .pins      (pins),
      .ba        (mem_ba),
      .addr      (mem_addr)
   );

   assign mem_cke    = 1'b1;
   assign mem_cs_n   = pins.cs_n;
   assign mem_ras_n  = pins.ras_n;
   assign mem_cas_n  = pins.cas_n;
   assign mem_we_n   = pins.we_n;
   assign init_ready = (state_q == ST_READY);

   // R2: every sequence command is followed by at least one NOP
   a_r2_cmd_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

   // R3: precharge on the pins always carries the all-bank bit
   a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !mem_ras_n && mem_cas_n && !mem_we_n) |-> mem_addr[10]);

   // R6: register loads only select the normal or the extended register
   a_r6_reg_select: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !mem_ras_n && !mem_cas_n && !mem_we_n) |->
         (mem_ba == BANK_W'(0) || mem_ba == BANK_W'(2)));

   // R7: ready only rises after a settling NOP
   a_r7_ready_after_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_ready) |-> $past(cmd == CMD_NOP));

   // R8: ready only drops because an accepted request arrived
   a_r8_drop_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init_ready) |-> $past(emrs_req && banks_idle));

   // R9: without an accepted request, ready holds
   a_r9_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (init_ready && !(emrs_req && banks_idle)) |=> init_ready);

endmodule

// File: tb/test_lpddr_init_seq.sv
`timescale 1ns/1ps
module test_lpddr_init_seq;

   localparam int ROW_W    = 13;
   localparam int BANK_W   = 2;
   localparam int T_STABLE = 37;
   localparam int T_RP     = 3;
   localparam int T_ARFC   = 5;
   localparam int T_MRD    = 3;
   localparam int N_AREF   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_burst_sel = 2'b00;
   logic cfg_interleave = 1'b0;
   logic [1:0] cfg_pasr_sel = 2'b00;
   logic [1:0] cfg_drive_sel = 2'b01;
   logic emrs_req = 1'b0;
   logic banks_idle = 1'b1;
   logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_ready;
   logic [BANK_W-1:0] mem_ba;
   logic [ROW_W-1:0] mem_addr;

   always #2.5 clk = ~clk;

   lpddr_init_seq #(
      .ROW_W(ROW_W), .BANK_W(BANK_W), .CAS_LAT(3), .T_STABLE(T_STABLE),
      .T_RP(T_RP), .T_ARFC(T_ARFC), .T_MRD(T_MRD), .N_AREF(N_AREF)
   ) i_lpddr_init_seq (
      .clk(clk), .rst_n(rst_n), .cfg_burst_sel(cfg_burst_sel),
      .cfg_interleave(cfg_interleave), .cfg_pasr_sel(cfg_pasr_sel),
      .cfg_drive_sel(cfg_drive_sel), .emrs_req(emrs_req), .banks_idle(banks_idle),
      .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
      .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba),
      .mem_addr(mem_addr), .init_ready(init_ready)
   );

   // kinds: 0 NOP, 1 precharge-all, 2 refresh, 3 mode load, 4 extended load
   typedef struct {
      int          at;
      int          kind;
      logic [1:0]  ba;
      logic [12:0] addr;
   } ev_t;

   ev_t   evq[$];
   int    n_checks = 0;
   int    n_fail = 0;
   int    cyc_n = 0;
   int    ready_at = -1;
   int    aref_seen = 0;
   int    emrs_seen = 0;
   string nop_tag = "R2";
   string ext_tag = "R6";
   string rdy_tag = "R7";

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc_n, act, exp);
      end
   endtask

   function automatic logic [12:0] exp_mrs();
      logic [12:0] w = '0;
      w[2:0] = (cfg_burst_sel == 2'b00) ? 3'd1 : (cfg_burst_sel == 2'b01) ? 3'd2 : 3'd3;
      w[3]   = cfg_interleave;
      w[6:4] = 3'd3;
      return w;
   endfunction

   function automatic logic [12:0] exp_emrs();
      logic [12:0] w = '0;
      w[2:0] = (cfg_pasr_sel == 2'b01) ? 3'd1 : (cfg_pasr_sel == 2'b10) ? 3'd2 : 3'd0;
      w[6:5] = cfg_drive_sel;
      return w;
   endfunction

   function automatic bit need_emrs();
      return (cfg_pasr_sel == 2'b01) || (cfg_pasr_sel == 2'b10) || (cfg_drive_sel != 2'b01);
   endfunction

   task automatic build_init();
      int t = T_STABLE;
      evq.delete();
      evq.push_back('{t, 1, 2'b00, 13'h0400});
      t += T_RP;
      for (int k = 0; k < N_AREF; k++) begin
         evq.push_back('{t, 2, 2'b00, 13'h0000});
         t += T_ARFC;
      end
      evq.push_back('{t, 3, 2'b00, exp_mrs()});
      t += T_MRD;
      if (need_emrs()) begin
         evq.push_back('{t, 4, 2'b10, exp_emrs()});
         t += T_MRD;
      end
      ready_at = t;
   endtask

   // one clock: compare every port with the model, then drive next inputs
   task automatic cyc(input bit req, input bit idle);
      int kind = 0;
      logic [1:0] eba = '0;
      logic [12:0] eaddr = '0;
      logic [3:0] epins;
      string tag;
      bit erdy;
      @(negedge clk);
      cyc_n++;
      if (evq.size() > 0 && evq[0].at == cyc_n) begin
         ev_t e = evq.pop_front();
         kind = e.kind; eba = e.ba; eaddr = e.addr;
      end
      case (kind)
         1: begin epins = 4'b0010; tag = "R3"; end
         2: begin epins = 4'b0001; tag = "R4"; aref_seen++; end
         3: begin epins = 4'b0000; tag = "R5"; end
         4: begin epins = 4'b0000; tag = ext_tag; emrs_seen++; end
         default: begin epins = 4'b0111; tag = nop_tag; end
      endcase
      check({mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr} ==
            {1'b1, epins, eba, eaddr}, tag, "command pins",
            32'({mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr}),
            32'({1'b1, epins, eba, eaddr}));
      erdy = (ready_at >= 0) && (cyc_n >= ready_at);
      check(init_ready == erdy, rdy_tag, "ready", 32'(init_ready), 32'(erdy));
      if (erdy && req && idle) begin
         evq.push_back('{cyc_n + 1, 4, 2'b10, exp_emrs()});
         ready_at = cyc_n + 1 + T_MRD;
      end
      emrs_req   = req;
      banks_idle = idle;
   endtask

   task automatic do_reset(input logic [1:0] bl, input logic il,
                           input logic [1:0] pasr, input logic [1:0] drv);
      @(negedge clk);
      rst_n = 1'b0;
      emrs_req = 1'b0;
      banks_idle = 1'b1;
      cfg_burst_sel = bl; cfg_interleave = il; cfg_pasr_sel = pasr; cfg_drive_sel = drv;
      repeat (3) begin
         @(negedge clk);
         // R1: reset state at the ports
         check({mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr, init_ready} ==
               {1'b1, 4'b0111, 2'b00, 13'h0, 1'b0}, "R1", "reset outputs",
               32'({mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba, mem_addr, init_ready}),
               32'({1'b1, 4'b0111, 2'b00, 13'h0, 1'b0}));
      end
      rst_n = 1'b1;
      cyc_n = 0;
      aref_seen = 0;
      emrs_seen = 0;
      build_init();
   endtask

   task automatic run_init(input bit req_during);
      bit need = need_emrs();
      nop_tag = req_during ? "R9" : "R2";
      rdy_tag = req_during ? "R9" : "R7";
      while (cyc_n < ready_at + 2)
         cyc(req_during && (cyc_n + 1 < ready_at), 1'b1);
      nop_tag = "R2";
      rdy_tag = "R7";
      check(aref_seen == N_AREF, "R4", "refresh count", 32'(aref_seen), 32'(N_AREF));
      check(emrs_seen == int'(need), "R6", "extended load count", 32'(emrs_seen), 32'(need));
   endtask

   initial begin
      // default settings: no extended load, then reprogram after ready
      do_reset(2'b01, 1'b0, 2'b00, 2'b01);
      run_init(1'b0);
      nop_tag = "R9"; rdy_tag = "R9";
      repeat (8) cyc(1'b1, 1'b0);
      repeat (2) cyc(1'b0, 1'b1);
      check(emrs_seen == 0, "R9", "request with busy banks", 32'(emrs_seen), 32'd0);
      cfg_pasr_sel = 2'b10; cfg_drive_sel = 2'b11;
      nop_tag = "R8"; ext_tag = "R8"; rdy_tag = "R8";
      cyc(1'b1, 1'b1);
      repeat (T_MRD + 4) cyc(1'b0, 1'b1);
      check(emrs_seen == 1, "R8", "reprogram load count", 32'(emrs_seen), 32'd1);
      check(aref_seen == N_AREF, "R8", "no repeated refresh", 32'(aref_seen), 32'(N_AREF));
      // default settings reprogrammed explicitly
      cfg_pasr_sel = 2'b00; cfg_drive_sel = 2'b01;
      cyc(1'b1, 1'b1);
      repeat (T_MRD + 3) cyc(1'b0, 1'b1);
      check(emrs_seen == 2, "R8", "default reprogram", 32'(emrs_seen), 32'd2);
      nop_tag = "R2"; ext_tag = "R6"; rdy_tag = "R7";

      // reset in the middle of bring-up, then half-array coverage
      do_reset(2'b10, 1'b1, 2'b01, 2'b01);
      repeat (T_STABLE + 6) cyc(1'b0, 1'b1);
      do_reset(2'b10, 1'b1, 2'b01, 2'b01);
      run_init(1'b1);

      // full drive strength, coverage code 11 means full array, 8-beat via 11
      do_reset(2'b11, 1'b0, 2'b11, 2'b00);
      run_init(1'b0);

      // 2-beat bursts, coverage 11 with half drive: no extended load
      do_reset(2'b00, 1'b1, 2'b11, 2'b01);
      run_init(1'b0);

      // quarter array, eighth drive
      do_reset(2'b01, 1'b1, 2'b10, 2'b11);
      run_init(1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule